// File: doc/BRIEF.md
# Link Change Wake Event Generator

This block turns changes of a physical-layer link-valid indication into a power-management wake request. The raw link signal is first brought into the local clock domain. A change then has to hold for a programmable number of cycles before it counts. Once it counts, whether the link came up or went down, a sticky status bit is set. The status bit sets in every device power state, and it sets whether or not the wake output is enabled.

The wake request is active low, and the block only ever drives it low, as an open-drain pin would be. It is low only while the status bit is set and two separate enables are both on. The first enable comes from the power-management control/status register. The second comes from the link-wake setting of the configure command. Software clears the status by writing 1 to it. The PHY link detection and the configuration-space decode live outside this block.

Top module: `link_wake_event`

## Requirements
- R1: When the filtered link state goes from invalid (0) to valid (1), `pme_sts` sets.
- R2: When the filtered link state goes from valid (1) to invalid (0), `pme_sts` sets.
- R3: The value on `pwr_state` (0 = D0 through 3 = D3) has no effect on event detection, on status or on `pme_n`.
- R4: `pme_sts` sets on a qualified change even while `pme_en` or `wake_en` is 0.
- R5: `pme_n` is 0 only while `pme_sts`, `pme_en` and `wake_en` are all 1, and it returns to 1 as soon as either enable drops.
- R6: Holding `sts_clr` at 1 across a clock edge clears `pme_sts` at that edge, and `pme_n` then returns to 1.
- R7: If a clear and a qualified change fall on the same edge, `pme_sts` is 1 after that edge.
- R8: `link_raw` passes through two synchronizer flops. A new level counts only once it has differed from the filtered state for `filt_len` consecutive cycles, so status rises at the (2+`filt_len`)-th edge after the change. A pulse shorter than `filt_len` cycles is ignored.
- R9: A `filt_len` of 0 behaves as 1, so status rises at the third edge after the change.
- R10: While `rst_n` is 0, `pme_sts` is 0 and `pme_n` is 1, and the filtered link state is invalid. A link that is already valid after reset therefore raises an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_raw | input | 1 | Unsynchronized link-valid indication from the PHY |
| filt_len | input | CNT_W | Number of stable cycles needed before a change counts (0 acts as 1) |
| pme_en | input | 1 | PME enable from the power-management control/status register |
| wake_en | input | 1 | Link-wake enable set by the configure command |
| pwr_state | input | 2 | Current device power state (D0 to D3) |
| sts_clr | input | 1 | Write-1-to-clear strobe for the status bit |
| pme_n | output | 1 | Active-low wake request, driven low only |
| pme_sts | output | 1 | Sticky link-change event status |

## Verification
A change on `link_raw` shows up on `pme_sts` exactly 2+`filt_len` rising edges after it is driven, and `pme_n` follows at that same edge. A clear takes effect on the edge it spans. An enable change reaches `pme_n` at once, with no edge needed. Each stimulus step is driven just after a rising edge, the bench waits the exact number of edges the step needs, and it samples one time unit later. Because of this, a result that arrives one cycle early or one cycle late fails its check. For the case where a clear meets an event on the same edge, the bench places the clear on that predicted edge.

// File: rtl/link_wake_event.sv
module link_wake_event #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_raw,
  input  logic [CNT_W-1:0] filt_len,
  input  logic             pme_en,
  input  logic             wake_en,
  input  logic [1:0]       pwr_state,
  input  logic             sts_clr,
  output logic             pme_n,
  output logic             pme_sts
);

  logic [1:0]       sync_q;
  logic             link_q;
  logic [CNT_W-1:0] run_q;
  logic             sts_q;

  wire [CNT_W-1:0] need   = (filt_len == '0) ? CNT_W'(1) : filt_len;
  wire             differ = sync_q[1] ^ link_q;
  wire             accept = differ && (({1'b0, run_q} + 1'b1) == {1'b0, need});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      link_q <= 1'b0;
      run_q  <= '0;
      sts_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], link_raw};
      run_q  <= (!differ || accept) ? '0 : run_q + 1'b1;
      if (accept) link_q <= sync_q[1];
      sts_q  <= accept | (sts_q & ~sts_clr);
    end
  end

  assign pme_sts = sts_q;
  assign pme_n   = ~(sts_q & pme_en & wake_en);

  // R1 R2: every accepted link change leaves status set
  a_r1_r2_change_sets_sts: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q != $past(link_q)) |-> pme_sts);

  // R8: an accepted level is the one the synchronizer presented
  a_r8_accept_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (link_q != $past(link_q)) |-> (link_q == $past(sync_q[1])));

  // R4 R8: status only rises on an accepted change
  a_r4_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pme_sts) |-> (link_q != $past(link_q)));

  // R6 R7: a clear drops status unless a change lands on the same edge
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts && sts_clr) |=> (!pme_sts || (link_q != $past(link_q))));

  // R5: wake request low implies all three conditions
  a_r5_low_needs_all: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_n |-> (pme_sts && pme_en && wake_en));

  // R3: power state is a defined level, never used for gating
  a_r3_state_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(pwr_state));

endmodule

// File: tb/link_wake_event_tb.sv
module link_wake_event_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_raw = 1'b0;
  logic [CNT_W-1:0] filt_len = 8'd3;
  logic pme_en = 1'b0;
  logic wake_en = 1'b0;
  logic [1:0] pwr_state = 2'd0;
  logic sts_clr = 1'b0;
  logic pme_n;
  logic pme_sts;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  link_wake_event #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_raw(link_raw), .filt_len(filt_len),
    .pme_en(pme_en), .wake_en(wake_en), .pwr_state(pwr_state),
    .sts_clr(sts_clr), .pme_n(pme_n), .pme_sts(pme_sts)
  );

  typedef struct packed {
    logic       raw;
    logic       clr;
    logic       pen;
    logic       wen;
    logic [1:0] pwr;
    logic [4:0] cyc;
    logic       sts;
    logic       pmen;
  } step_t;

  localparam int NSTEP = 15;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 5'd6, 1'b0, 1'b1}, // R10 idle, link stays invalid
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 5'd4, 1'b0, 1'b1}, // R8 not yet qualified
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 5'd1, 1'b1, 1'b0}, // R1 up event at edge 5
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 5'd1, 1'b0, 1'b1}, // R6 clear
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 5'd5, 1'b1, 1'b1}, // R2 R4 down event, output gated
    '{1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 5'd1, 1'b1, 1'b1}, // R5 wake enable off
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 5'd1, 1'b1, 1'b0}, // R5 both on
    '{1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 5'd1, 1'b1, 1'b1}, // R5 pme enable drops
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 5'd1, 1'b0, 1'b1}, // R6 clear
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 5'd2, 1'b0, 1'b1}, // R8 glitch start
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 5'd8, 1'b0, 1'b1}, // R8 glitch ignored
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 5'd5, 1'b1, 1'b0}, // R3 event in D3
    '{1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 5'd1, 1'b0, 1'b1}, // R6 clear
    '{1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 5'd5, 1'b1, 1'b0}, // R3 event in D2
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 5'd1, 1'b0, 1'b1}  // R6 clear
  };

  task automatic check(input string tag, input logic exp_sts, input logic exp_n);
    checks++;
    if (pme_sts !== exp_sts || pme_n !== exp_n) begin
      fails++;
      $display("FAIL %s: pme_sts=%b pme_n=%b expected pme_sts=%b pme_n=%b",
               tag, pme_sts, pme_n, exp_sts, exp_n);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    edges(3);
    check("R10 reset state", 1'b0, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      link_raw  = STEPS[i].raw;
      sts_clr   = STEPS[i].clr;
      pme_en    = STEPS[i].pen;
      wake_en   = STEPS[i].wen;
      pwr_state = STEPS[i].pwr;
      edges(int'(STEPS[i].cyc));
      check($sformatf("table row %0d", i), STEPS[i].sts, STEPS[i].pmen);
    end
    sts_clr = 1'b0;
    pwr_state = 2'd0;

    // R7: clear on the same edge as a new change
    link_raw = 1'b1;
    edges(5);
    check("R1 up before R7", 1'b1, 1'b0);
    link_raw = 1'b0;
    edges(4);
    sts_clr = 1'b1;
    edges(1);
    check("R7 clear meets event", 1'b1, 1'b0);
    sts_clr = 1'b0;
    edges(1);
    check("R7 status held", 1'b1, 1'b0);
    sts_clr = 1'b1;
    edges(1);
    sts_clr = 1'b0;
    check("R6 clear after R7", 1'b0, 1'b1);

    // R9: zero length acts as one
    filt_len = '0;
    link_raw = 1'b1;
    edges(2);
    check("R9 not before edge 3", 1'b0, 1'b1);
    edges(1);
    check("R9 event at edge 3", 1'b1, 1'b0);
    sts_clr = 1'b1;
    edges(1);
    sts_clr = 1'b0;

    // R8: longer filter
    filt_len = 8'd10;
    link_raw = 1'b0;
    edges(11);
    check("R8 long filter early", 1'b0, 1'b1);
    edges(1);
    check("R8 long filter at edge 12", 1'b1, 1'b0);

    // R10: reset while status set
    rst_n = 1'b0;
    #1;
    check("R10 reset clears status", 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule